// File: doc/BRIEF.md
# Display auxiliary channel request engine

This block runs one request/reply exchange on a display auxiliary side channel. The exchange is either a native register access (a burst write or read of up to `MAX_PAYLOAD` bytes) or a single byte moved over the tunnelled I2C path. A requester gives a kind, a 16-bit address, a length, write data and, for I2C, a flag that says the byte ends the I2C transfer. The engine builds the request header, streams the request bytes to a byte-level transmitter over a valid/ready link, and waits for the reply bundle that the transport returns.

The engine sorts each reply in two stages. Transport-level status comes first. Then the native reply field is read. For I2C requests only, the I2C reply field is read after a native acknowledge. Each outcome ends the request, retries it at once, or retries it after a fixed wait of `DEFER_US` microseconds, which the engine counts in clock cycles. All retries share one budget of `MAX_TRIES` attempts. On completion the engine pulses `done` with an error code, and for reads it returns the reply bytes clipped to the requested count.

Top module: `aux_xact_engine`

## Requirements
- R1: `req_kind` encodes 0 = native write, 1 = native read, 2 = I2C write, 3 = I2C read. Every request starts with four header bytes. Byte 0 is address[7:0]. Byte 1 is address[15:8]. Byte 2 carries the command in bits 7:4: 0x8 for native write, 0x9 for native read, 0x0 for I2C write, 0x1 for I2C read. Bits 3:0 of byte 2 are zero.
- R2: Header byte 3 holds the total request byte count (modulo 16) in bits 7:4. Its bits 3:0 hold `req_len`−1 for native kinds and 0 for I2C kinds. A native write sends `req_len` payload bytes after the header, lowest byte of `req_wdata` first.
- R3: A native request with `req_len` of 0 or above `MAX_PAYLOAD` is refused. `done` rises one cycle after `start`, with error code 1. No byte appears on the transmit link.
- R4: A native read sends only the 4-byte header. `rd_len` is the smaller of `rx_len` and `req_len`. The bytes of `rd_data` at or above `rd_len` read as zero. Writes return `rd_len` = 0.
- R5: Transport status 1 (timeout) ends the request with code 2. Status 3 (transport error) ends it with code 3. Status 2 (busy) uses up one attempt, and the request is sent again within a few cycles.
- R6: At most `MAX_TRIES` attempts are made. When the last allowed attempt still asks for a retry, the request ends with code 7 and no wait.
- R7: The native reply field is `rx_reply[5:4]`: 0 = ACK, 1 = NACK, 2 = DEFER, 3 = invalid. DEFER waits at least `DEFER_US`×`CYC_PER_US` cycles before the next attempt. NACK ends the request with code 4. Invalid ends it with code 5.
- R8: For I2C kinds, bit 6 of header byte 2 (the continue flag) is set when `req_last` is 0 and clear when `req_last` is 1.
- R9: The I2C reply field is `rx_reply[7:6]`, using the same coding as the native field. It is read only for I2C kinds and only after a native ACK. ACK completes the request. NACK ends it with code 6. DEFER waits and retries within the same budget. Invalid ends it with code 5. For native kinds this field has no effect.
- R10: An I2C read sends 4 bytes, with 0x40 in byte 3, and returns at most one byte. An I2C write sends 5 bytes, with 0x50 in byte 3, and its fifth byte is `req_wdata[7:0]`.
- R11: `busy` is high from the cycle after an accepted `start` through the cycle in which `done` is high, and is low after that. `done` lasts one cycle. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transaction |
| req_kind | input | 2 | Transaction kind |
| req_last | input | 1 | I2C byte ends the I2C transfer |
| req_addr | input | ADDR_W | Target address |
| req_len | input | LEN_W | Native byte count |
| req_wdata | input | MAX_PAYLOAD*8 | Write bytes, byte 0 in bits 7:0 |
| tx_valid | output | 1 | Request byte valid |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of the request |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_valid | input | 1 | Reply bundle valid for one cycle |
| rx_status | input | 2 | Transport status |
| rx_reply | input | 8 | Reply code byte |
| rx_len | input | LEN_W | Reply data byte count |
| rx_data | input | MAX_PAYLOAD*8 | Reply data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| err | output | 3 | Completion code, 0 = success |
| rd_len | output | LEN_W | Returned byte count |
| rd_data | output | MAX_PAYLOAD*8 | Returned bytes |

## Verification
The transport stub replays scripted reply sequences, so each run of outcomes separates one decision of the classifier. Examples: busy followed by ACK, defer followed by ACK, four busy or four defer replies, and native ACK combined with each I2C reply code. Reads with a reply longer than the request and with a reply shorter than the request show whether the clip takes the smaller count and zeros the rest. Native write lengths of 0, 16 and 17 locate the refusal boundary, and I2C requests with the last flag set and clear show the continue bit. Reply codes whose I2C field is set on native requests show that the I2C field is ignored when it must be. The stub measures the gap between a reply and the next request, which separates a retry with a wait from an immediate one.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

   typedef enum logic [1:0] {
      K_NWR = 2'd0,
      K_NRD = 2'd1,
      K_IWR = 2'd2,
      K_IRD = 2'd3
   } kind_e;

   typedef enum logic [2:0] {
      E_OK       = 3'd0,
      E_LEN      = 3'd1,
      E_TIMEOUT  = 3'd2,
      E_XPORT    = 3'd3,
      E_NNACK    = 3'd4,
      E_BADREPLY = 3'd5,
      E_INACK    = 3'd6,
      E_EXHAUST  = 3'd7
   } err_e;

   typedef enum logic [1:0] {
      A_FINISH,
      A_ABORT,
      A_AGAIN,
      A_WAIT
   } act_e;

   localparam logic [3:0] CMD_NWR = 4'h8;
   localparam logic [3:0] CMD_NRD = 4'h9;
   localparam logic [3:0] CMD_IWR = 4'h0;
   localparam logic [3:0] CMD_IRD = 4'h1;
   localparam logic [3:0] CMD_CONT = 4'h4;

   localparam logic [1:0] XS_OK      = 2'd0;
   localparam logic [1:0] XS_TIMEOUT = 2'd1;
   localparam logic [1:0] XS_BUSY    = 2'd2;
   localparam logic [1:0] XS_ERROR   = 2'd3;

   localparam logic [1:0] RC_ACK   = 2'd0;
   localparam logic [1:0] RC_NACK  = 2'd1;
   localparam logic [1:0] RC_DEFER = 2'd2;

endpackage

// File: rtl/aux_req_framer.sv
module aux_req_framer
   import aux_xact_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int MAX_PAYLOAD = 16,
   parameter int LEN_W       = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     go,
   input  logic [1:0]               kind,
   input  logic                     last_xfer,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [LEN_W-1:0]         len,
   input  logic [MAX_PAYLOAD*8-1:0] wdata,
   output logic                     tx_valid,
   output logic [7:0]               tx_data,
   output logic                     tx_last,
   input  logic                     tx_ready,
   output logic                     sent
);
   localparam int FRAME_MAX = MAX_PAYLOAD + 4;
   localparam int IDX_W     = $clog2(FRAME_MAX + 1);

   logic             active;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] msg_cnt;
   logic [7:0]       addr_lo, addr_hi;
   logic [3:0]       cmd_nib, len_nib;
   logic [7:0]       pay_byte;
   logic             is_i2c;

   assign is_i2c  = kind[1];
   assign addr_lo = addr[7:0];

   generate
      if (ADDR_W > 8) begin : g_wide_addr
         logic [15:0] a16;
         assign a16     = 16'(addr);
         assign addr_hi = a16[15:8];
      end else begin : g_narrow_addr
         assign addr_hi = 8'h00;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         K_NWR:   begin msg_cnt = IDX_W'(4) + IDX_W'(len); cmd_nib = CMD_NWR; end
         K_NRD:   begin msg_cnt = IDX_W'(4);               cmd_nib = CMD_NRD; end
         K_IWR:   begin msg_cnt = IDX_W'(5);
                        cmd_nib = CMD_IWR | (last_xfer ? 4'h0 : CMD_CONT); end
         default: begin msg_cnt = IDX_W'(4);
                        cmd_nib = CMD_IRD | (last_xfer ? 4'h0 : CMD_CONT); end
      endcase
      len_nib = is_i2c ? 4'h0 : 4'(len - LEN_W'(1));
   end

   always_comb begin
      int pk;
      pk = int'(idx) - 4;
      pay_byte = 8'h00;
      if (pk >= 0 && pk < MAX_PAYLOAD)
         pay_byte = wdata[pk*8 +: 8];
   end

   always_comb begin
      unique case (idx)
         IDX_W'(0): tx_data = addr_lo;
         IDX_W'(1): tx_data = addr_hi;
         IDX_W'(2): tx_data = {cmd_nib, 4'h0};
         IDX_W'(3): tx_data = {msg_cnt[3:0], len_nib};
         default:   tx_data = pay_byte;
      endcase
   end

   assign tx_valid = active;
   assign tx_last  = active && (idx == msg_cnt - IDX_W'(1));
   assign sent     = tx_last && tx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (go) begin
         active <= 1'b1;
         idx    <= '0;
      end else if (active && tx_ready) begin
         if (tx_last) active <= 1'b0;
         else         idx    <= idx + IDX_W'(1);
      end
   end

   // R1: a byte offered and not taken stays on the link unchanged
   assert_tx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

endmodule

// File: rtl/aux_reply_judge.sv
module aux_reply_judge
   import aux_xact_pkg::*;
#(
   parameter int NATIVE_LSB = 4,
   parameter int I2C_LSB    = 6
) (
   input  logic [1:0] status,
   input  logic [7:0] reply,
   input  logic       is_i2c,
   output act_e       act,
   output err_e       code
);
   logic [1:0] nat_f, i2c_f;
   assign nat_f = reply[NATIVE_LSB +: 2];
   assign i2c_f = reply[I2C_LSB +: 2];

   always_comb begin
      act  = A_ABORT;
      code = E_BADREPLY;
      unique case (status)
         XS_TIMEOUT: code = E_TIMEOUT;
         XS_ERROR:   code = E_XPORT;
         XS_BUSY:    act  = A_AGAIN;
         default: begin
            unique case (nat_f)
               RC_NACK:  code = E_NNACK;
               RC_DEFER: act  = A_WAIT;
               RC_ACK: begin
                  if (!is_i2c) begin
                     act  = A_FINISH;
                     code = E_OK;
                  end else begin
                     unique case (i2c_f)
                        RC_ACK:   begin act = A_FINISH; code = E_OK; end
                        RC_NACK:  code = E_INACK;
                        RC_DEFER: act  = A_WAIT;
                        default:  code = E_BADREPLY;
                     endcase
                  end
               end
               default: code = E_BADREPLY;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
   import aux_xact_pkg::*;
#(
   parameter int MAX_TRIES = 4,
   parameter int DEFER_CYC = 400
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       reject,
   input  logic       sent,
   input  logic       rx_valid,
   input  act_e       act,
   input  err_e       code,
   output logic       go,
   output logic       capture,
   output logic       busy,
   output logic       done,
   output logic [2:0] err
);
   localparam int TRY_W = $clog2(MAX_TRIES + 1);
   localparam int CNT_W = $clog2(DEFER_CYC + 1);

   typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_HOLD, S_FIN} st_e;

   st_e              st;
   logic [TRY_W-1:0] tries;
   logic [TRY_W:0]   tries_n;
   logic [CNT_W-1:0] cnt;
   err_e             err_q;
   logic             reply_seen, spent;

   assign tries_n    = {1'b0, tries} + (TRY_W+1)'(1);
   assign spent      = tries_n >= (TRY_W+1)'(MAX_TRIES);
   assign reply_seen = (st == S_WAIT) && rx_valid;

   assign go = ((st == S_IDLE) && start && !reject)
            || (reply_seen && act == A_AGAIN && !spent)
            || ((st == S_HOLD) && cnt == '0);
   assign capture = reply_seen && act == A_FINISH;
   assign busy    = st != S_IDLE;
   assign done    = st == S_FIN;
   assign err     = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         tries <= '0;
         cnt   <= '0;
         err_q <= E_OK;
      end else begin
         unique case (st)
            S_IDLE: if (start) begin
               tries <= '0;
               if (reject) begin err_q <= E_LEN; st <= S_FIN;  end
               else        begin err_q <= E_OK;  st <= S_SEND; end
            end
            S_SEND: if (sent) st <= S_WAIT;
            S_WAIT: if (rx_valid) begin
               tries <= tries_n[TRY_W-1:0];
               unique case (act)
                  A_FINISH: begin err_q <= E_OK; st <= S_FIN; end
                  A_ABORT:  begin err_q <= code; st <= S_FIN; end
                  A_AGAIN:  if (spent) begin err_q <= E_EXHAUST; st <= S_FIN; end
                            else st <= S_SEND;
                  default:  if (spent) begin err_q <= E_EXHAUST; st <= S_FIN; end
                            else begin
                               cnt <= CNT_W'(DEFER_CYC - 1);
                               st  <= S_HOLD;
                            end
               endcase
            end
            S_HOLD: if (cnt == '0) st <= S_SEND;
                    else cnt <= cnt - CNT_W'(1);
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R11: completion is a single-cycle pulse
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: the attempt count never passes the budget
   assert_try_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tries) <= MAX_TRIES);
   // R7: nothing is handed to the transmitter during a defer wait
   assert_defer_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      st == S_HOLD |-> !sent);

endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
   import aux_xact_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int MAX_PAYLOAD = 16,
   parameter int MAX_TRIES   = 4,
   parameter int CYC_PER_US  = 100,
   parameter int DEFER_US    = 400,
   localparam int LEN_W      = $clog2(MAX_PAYLOAD + 1),
   localparam int DATA_W     = MAX_PAYLOAD * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        req_kind,
   input  logic              req_last,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [1:0]        rx_status,
   input  logic [7:0]        rx_reply,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic [DATA_W-1:0] rx_data,
   output logic              busy,
   output logic              done,
   output logic [2:0]        err,
   output logic [LEN_W-1:0]  rd_len,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEFER_CYC = CYC_PER_US * DEFER_US;

   generate
      if (MAX_PAYLOAD < 1 || MAX_PAYLOAD > 16) begin : g_bad_payload
         $error("MAX_PAYLOAD must lie in 1..16");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 1..16");
      end
      if (MAX_TRIES < 1 || DEFER_CYC < 1) begin : g_bad_retry
         $error("MAX_TRIES and the defer wait must be positive");
      end
   endgenerate

   logic [1:0]        kind_q;
   logic              last_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q, want_q, keep;
   logic [DATA_W-1:0] wdata_q;
   logic              reject_now, accept, go, sent, capture;
   act_e              act;
   err_e              code;

   assign reject_now = !req_kind[1] &&
                       (req_len == '0 || 32'(req_len) > MAX_PAYLOAD);
   assign accept     = start && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= K_NWR;
         last_q  <= 1'b1;
         addr_q  <= '0;
         len_q   <= '0;
         want_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         kind_q  <= req_kind;
         last_q  <= req_last;
         addr_q  <= req_addr;
         len_q   <= req_len;
         wdata_q <= req_wdata;
         unique case (req_kind)
            K_NRD:   want_q <= req_len;
            K_IRD:   want_q <= LEN_W'(1);
            default: want_q <= '0;
         endcase
      end
   end

   aux_req_framer #(.ADDR_W(ADDR_W), .MAX_PAYLOAD(MAX_PAYLOAD), .LEN_W(LEN_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .go(go), .kind(kind_q), .last_xfer(last_q),
      .addr(addr_q), .len(len_q), .wdata(wdata_q), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .sent(sent));

   aux_reply_judge #(.NATIVE_LSB(4), .I2C_LSB(6)) u_judge (
      .status(rx_status), .reply(rx_reply), .is_i2c(kind_q[1]),
      .act(act), .code(code));

   aux_retry_ctrl #(.MAX_TRIES(MAX_TRIES), .DEFER_CYC(DEFER_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .reject(reject_now), .sent(sent),
      .rx_valid(rx_valid), .act(act), .code(code), .go(go), .capture(capture),
      .busy(busy), .done(done), .err(err));

   assign keep = (rx_len < want_q) ? rx_len : want_q;

   always_ff @(posedge clk) begin
      if (!rst_n || accept) rd_len <= '0;
      else if (capture)     rd_len <= keep;
   end

   genvar gi;
   generate
      for (gi = 0; gi < MAX_PAYLOAD; gi++) begin : g_clip
         always_ff @(posedge clk) begin
            if (!rst_n || accept)
               rd_data[gi*8 +: 8] <= 8'h00;
            else if (capture)
               rd_data[gi*8 +: 8] <= (32'(keep) > gi) ? rx_data[gi*8 +: 8] : 8'h00;
         end
      end
   endgenerate

   // R3: a refused request finishes next cycle with the length code and sends nothing
   assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && reject_now |=> done && err == 3'(E_LEN) && !tx_valid);
   // R4: returned count never exceeds what was asked for
   assert_clip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rd_len <= want_q);
   // R11: no byte is offered while the engine is idle
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_valid);

endmodule

// File: tb/test_aux_xact_engine.sv
module test_aux_xact_engine;
   import aux_xact_pkg::*;

   localparam int MAXP = 16, LW = 5, DW = MAXP * 8;
   localparam int CPU = 1, DUS = 400, DCYC = CPU * DUS, TRIES = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          start = 0, req_last = 1, tx_ready = 0, rx_valid = 0;
   logic [1:0]    req_kind = 0, rx_status = 0;
   logic [15:0]   req_addr = 0;
   logic [LW-1:0] req_len = 0, rx_len = 0, rd_len;
   logic [DW-1:0] req_wdata = 0, rx_data = 0, rd_data;
   logic [7:0]    rx_reply = 0, tx_data;
   logic          tx_valid, tx_last, busy, done;
   logic [2:0]    err;

   aux_xact_engine #(.ADDR_W(16), .MAX_PAYLOAD(MAXP), .MAX_TRIES(TRIES),
                     .CYC_PER_US(CPU), .DEFER_US(DUS)) i_aux_xact_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .req_kind(req_kind),
      .req_last(req_last), .req_addr(req_addr), .req_len(req_len),
      .req_wdata(req_wdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_ready(tx_ready), .rx_valid(rx_valid),
      .rx_status(rx_status), .rx_reply(rx_reply), .rx_len(rx_len),
      .rx_data(rx_data), .busy(busy), .done(done), .err(err),
      .rd_len(rd_len), .rd_data(rd_data));

   typedef struct { logic [7:0] b; string tag; } xb_t;
   typedef struct { logic [1:0] st; logic [7:0] ack; logic [LW-1:0] len;
                    logic [DW-1:0] data; int waits; string tag; } rsp_t;
   typedef struct { logic [2:0] err; logic [LW-1:0] rlen; logic [DW-1:0] rdata;
                    int tries; string tag; } exp_t;

   xb_t  xq[$];
   rsp_t rq[$];
   exp_t sq[$];

   int n_chk = 0, n_pass = 0, cyc = 0, done_cnt = 0;
   int tries_seen = 0, pend_wait = -1, last_rsp_cyc = 0, rsp_cnt = -1;
   bit in_frame = 0, prev_done = 0;
   string pend_tag = "";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (ok) n_pass++;
      else $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
   endtask

   // transport stub and result monitor
   always @(negedge clk) begin
      rx_valid = 1'b0;
      if (done) begin
         exp_t e;
         chk(!prev_done, "R11", "done wider than one cycle", 1, 0);
         chk(busy === 1'b1, "R11", "busy during done", DW'(busy), 1);
         if (sq.size() == 0) chk(0, "R11", "unexpected completion", 1, 0);
         else begin
            e = sq.pop_front();
            chk(err === e.err, e.tag, "err code", DW'(err), DW'(e.err));
            chk(rd_len === e.rlen, e.tag, "rd_len", DW'(rd_len), DW'(e.rlen));
            chk(rd_data === e.rdata, e.tag, "rd_data", rd_data, e.rdata);
            chk(tries_seen == e.tries, e.tag, "attempt count", DW'(tries_seen), DW'(e.tries));
         end
         tries_seen = 0;
         pend_wait  = -1;
         done_cnt++;
      end
      prev_done = done;
      if (rsp_cnt > 0) rsp_cnt--;
      else if (rsp_cnt == 0) begin
         rsp_cnt = -1;
         if (rq.size() == 0) chk(0, "R5", "no scripted reply left", 0, 1);
         else begin
            rsp_t r;
            r = rq.pop_front();
            rx_status = r.st; rx_reply = r.ack; rx_len = r.len; rx_data = r.data;
            rx_valid = 1'b1;
            pend_wait = r.waits; pend_tag = r.tag; last_rsp_cyc = cyc;
         end
      end
      tx_ready = (cyc % 3) != 1;
      if (tx_valid && !in_frame) begin
         in_frame = 1;
         tries_seen++;
         if (pend_wait == 1)
            chk(cyc - last_rsp_cyc >= DCYC, pend_tag, "defer gap too short",
                DW'(cyc - last_rsp_cyc), DW'(DCYC));
         else if (pend_wait == 0)
            chk(cyc - last_rsp_cyc <= 4, pend_tag, "immediate retry late",
                DW'(cyc - last_rsp_cyc), 4);
         pend_wait = -1;
      end
      if (tx_valid && tx_ready) begin
         if (xq.size() == 0) chk(0, "R3", "unexpected request byte", DW'(tx_data), 0);
         else begin
            xb_t x;
            x = xq.pop_front();
            chk(tx_data === x.b, x.tag, "request byte", DW'(tx_data), DW'(x.b));
         end
         if (tx_last) begin in_frame = 0; rsp_cnt = 2; end
      end
   end

   function automatic void push_frame(input logic [1:0] k, input bit lst,
         input logic [15:0] a, input logic [LW-1:0] n, input logic [DW-1:0] wd);
      logic [7:0] b2, b3;
      int cnt;
      bit i2c;
      i2c = k[1];
      case (k)
         2'd0: begin b2 = 8'h80; cnt = 4 + int'(n); end
         2'd1: begin b2 = 8'h90; cnt = 4; end
         2'd2: begin b2 = lst ? 8'h00 : 8'h40; cnt = 5; end
         default: begin b2 = lst ? 8'h10 : 8'h50; cnt = 4; end
      endcase
      b3 = {4'(cnt), i2c ? 4'h0 : 4'(n - 1)};
      xq.push_back('{a[7:0], "R1"});
      xq.push_back('{a[15:8], "R1"});
      xq.push_back('{b2, i2c ? "R8" : "R1"});
      xq.push_back('{b3, i2c ? "R10" : "R2"});
      for (int i = 4; i < cnt; i++)
         xq.push_back('{wd[(i-4)*8 +: 8], i2c ? "R10" : "R2"});
   endfunction

   function automatic logic [DW-1:0] clip(input logic [DW-1:0] d, input int n);
      logic [DW-1:0] r;
      r = '0;
      for (int i = 0; i < n; i++) r[i*8 +: 8] = d[i*8 +: 8];
      return r;
   endfunction

   task automatic rsp(input logic [1:0] st, input logic [7:0] ack, input int n,
                      input logic [DW-1:0] d, input int waits, input string tag);
      rq.push_back('{st, ack, LW'(n), d, waits, tag});
   endtask

   task automatic xact(input logic [1:0] k, input bit lst, input logic [15:0] a,
         input int n, input logic [DW-1:0] wd, input int tries, input err_e e,
         input int rl, input logic [DW-1:0] rd, input string tag, input bit poke = 0);
      int target;
      for (int t = 0; t < tries; t++) push_frame(k, lst, a, LW'(n), wd);
      sq.push_back('{3'(e), LW'(rl), rd, tries, tag});
      target = done_cnt + 1;
      @(negedge clk);
      start = 1; req_kind = k; req_last = lst; req_addr = a;
      req_len = LW'(n); req_wdata = wd;
      @(negedge clk);
      start = 0;
      if (e == E_LEN) chk(done === 1'b1, "R3", "refusal not next cycle", DW'(done), 1);
      else            chk(busy === 1'b1, "R11", "busy after accept", DW'(busy), 1);
      if (poke) begin
         @(negedge clk); @(negedge clk);
         start = 1; req_kind = K_NWR; req_len = 3; req_addr = 16'hFFFF;
         @(negedge clk);
         start = 0;
      end
      while (done_cnt < target) @(negedge clk);
      @(negedge clk);
      chk(busy === 1'b0, "R11", "busy after done", DW'(busy), 0);
      @(negedge clk);
      if (poke) chk(done_cnt == target, "R11", "start while busy not ignored",
                    DW'(done_cnt), DW'(target));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "R11", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] big;
      repeat (3) @(negedge clk);
      chk(busy === 0 && done === 0 && tx_valid === 0, "R11", "reset state",
          DW'({busy, done, tx_valid}), 0);
      rst_n = 1;
      @(negedge clk);

      rsp(XS_OK, 8'h00, 0, 0, -1, "R2");
      xact(K_NWR, 1, 16'h1234, 2, 128'hBBAA, 1, E_OK, 0, 0, "R2");
      rsp(XS_OK, 8'h00, 6, 128'h665544332211, -1, "R4");
      xact(K_NRD, 1, 16'h0200, 4, 0, 1, E_OK, 4, 128'h44332211, "R4");
      rsp(XS_OK, 8'h00, 3, 128'h998877CCBBAA, -1, "R4");
      xact(K_NRD, 1, 16'hABCD, 8, 0, 1, E_OK, 3, 128'hCCBBAA, "R4");
      xact(K_NWR, 1, 16'h0010, 17, 0, 0, E_LEN, 0, 0, "R3");
      xact(K_NRD, 1, 16'h0010, 0, 0, 0, E_LEN, 0, 0, "R3");
      for (int i = 0; i < MAXP; i++) big[i*8 +: 8] = 8'(8'h11 * (i + 1));
      rsp(XS_OK, 8'h00, 0, 0, -1, "R2");
      xact(K_NWR, 1, 16'h0F0E, 16, big, 1, E_OK, 0, 0, "R2");

      rsp(XS_BUSY, 8'h00, 0, 0, 0, "R5");
      rsp(XS_BUSY, 8'h00, 0, 0, 0, "R5");
      rsp(XS_OK, 8'h00, 1, 128'h7E, -1, "R5");
      xact(K_NRD, 1, 16'h0101, 1, 0, 3, E_OK, 1, 128'h7E, "R5");
      for (int i = 0; i < 4; i++) rsp(XS_BUSY, 8'h00, 0, 0, 0, "R6");
      xact(K_NWR, 1, 16'h0102, 1, 128'h55, 4, E_EXHAUST, 0, 0, "R6");
      rsp(XS_TIMEOUT, 8'h00, 0, 0, -1, "R5");
      xact(K_NRD, 1, 16'h0103, 2, 0, 1, E_TIMEOUT, 0, 0, "R5");
      rsp(XS_ERROR, 8'h00, 0, 0, -1, "R5");
      xact(K_NWR, 1, 16'h0104, 1, 128'h01, 1, E_XPORT, 0, 0, "R5");

      rsp(XS_OK, 8'h20, 0, 0, 1, "R7");
      rsp(XS_OK, 8'h00, 0, 0, -1, "R7");
      xact(K_NWR, 1, 16'h0200, 1, 128'h42, 2, E_OK, 0, 0, "R7");
      rsp(XS_OK, 8'h10, 0, 0, -1, "R7");
      xact(K_NRD, 1, 16'h0201, 1, 0, 1, E_NNACK, 0, 0, "R7");
      rsp(XS_OK, 8'h30, 0, 0, -1, "R7");
      xact(K_NRD, 1, 16'h0202, 1, 0, 1, E_BADREPLY, 0, 0, "R7");
      rsp(XS_OK, 8'h40, 2, 128'hBEEF, -1, "R9");
      xact(K_NRD, 1, 16'h0203, 2, 0, 1, E_OK, 2, 128'hBEEF, "R9");

      rsp(XS_OK, 8'h00, 1, 128'h335A, -1, "R10");
      xact(K_IRD, 0, 16'h0050, 1, 0, 1, E_OK, 1, 128'h5A, "R10");
      rsp(XS_OK, 8'h00, 0, 0, -1, "R10");
      xact(K_IWR, 1, 16'h0050, 1, 128'hC3, 1, E_OK, 0, 0, "R10");
      rsp(XS_OK, 8'h40, 0, 0, -1, "R9");
      xact(K_IRD, 1, 16'h0050, 1, 0, 1, E_INACK, 0, 0, "R9");
      rsp(XS_OK, 8'h80, 0, 0, 1, "R9");
      rsp(XS_OK, 8'h00, 0, 0, -1, "R9");
      xact(K_IWR, 0, 16'h0051, 1, 128'h9D, 2, E_OK, 0, 0, "R9");
      rsp(XS_OK, 8'h60, 0, 0, 1, "R9");
      rsp(XS_OK, 8'hC0, 0, 0, -1, "R9");
      xact(K_IRD, 0, 16'h0052, 1, 0, 2, E_BADREPLY, 0, 0, "R9");

      for (int i = 0; i < 4; i++) rsp(XS_OK, 8'h20, 0, 0, (i < 3) ? 1 : -1, "R6");
      xact(K_NWR, 1, 16'h0300, 1, 128'h77, 4, E_EXHAUST, 0, 0, "R6");

      rsp(XS_OK, 8'h00, 2, 128'h1357, -1, "R11");
      xact(K_NRD, 1, 16'h0400, 2, 0, 1, E_OK, 2, 128'h1357, "R11", 1);

      chk(xq.size() == 0 && rq.size() == 0, "R1", "leftover scripted items",
          DW'(xq.size() + rq.size()), 0);
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
   end

endmodule